// File: doc/BRIEF.md
# Light-Sensor Serial Target Interface

This block is the two-wire serial (I2C / SMBus) target front end of a light-sensor die. It samples the clock and data lines with the system clock, drives the data line open-drain through a single output-enable, and gives a 16-bit register file access through a pointer. A write transfer first loads the register pointer and then carries a high byte and a low byte. A read transfer returns the register the pointer selects, high byte first. The pointer keeps its value from one transfer to the next, so software can poll one register by sending repeated reads with no new pointer write.

Its 7-bit bus address is `10001` followed by two bits taken from a strap input. The strap is captured at every START. The block also acts on several bus-wide events. The general-call address followed by the command byte `06h` restores register defaults and clears the pointer. A high-speed master code is left unacknowledged and puts the block into high-speed mode until the next STOP. A clock line held low for a configurable number of milliseconds returns the bus engine to idle. When the register file reports a pending latched alert, the block answers a read of the alert-response address. It sends its own address with the high-threshold flag as the final bit. If another target wins arbitration, it backs off.

Top module: `sensor_i2c_target`

## Requirements
- R1: The block acknowledges an address byte whose upper seven bits equal `10001` followed by `strap_sel[1:0]`, with codes 0, 1, 2 and 3 giving low address bits 00, 01, 10 and 11. The strap is captured at START. It leaves SDA released, with no acknowledge, for any other address that no other rule accepts.
- R2: In a write transfer, the first data byte loads the pointer, the second is the high byte and the third is the low byte. All three are acknowledged. When the third byte is acknowledged, `reg_wr` pulses for one cycle with `reg_addr` equal to the pointer and `reg_wdata` equal to {high, low}. A fourth data byte is not acknowledged.
- R3: In a read transfer, `reg_rd` pulses once when the address is acknowledged, and the word at the pointer is captured at that moment. The block sends the high byte and then the low byte, each MSB first. If the master acknowledges the low byte as well, the two bytes repeat alternately. The pointer keeps its value across transfers until a pointer write or a general-call reset.
- R4: After the master sends NACK on a read byte, the block releases SDA and drives no more bits until the next START.
- R5: The address byte `00h` followed by the byte `06h` is acknowledged twice. It pulses `defaults_rst` for one cycle and clears the pointer to 0. If any other byte follows `00h`, that byte is not acknowledged and no pulse is produced.
- R6: An address byte of the form `00001xxx` is not acknowledged and sets `hs_mode`. `hs_mode` stays set through repeated STARTs and clears at STOP.
- R7: If SCL stays low for TIMEOUT_MS periods of CLK_PER_MS system clocks, the engine returns to idle and releases SDA. A normal transfer works afterwards.
- R8: When `alert_pend` is 1, a read of address `0001100` is acknowledged. The block then sends {`10001`, strap bits, `high_flag`}, and `alert_clr` pulses after the eighth bit. When `alert_pend` is 0, that address is not acknowledged.
- R9: During the alert-response byte, if the block releases SDA for a 1 and samples SDA low, it stops driving for the rest of the byte and does not pulse `alert_clr`.
- R10: After reset, SDA is released and `hs_mode` is 0. The block starts driving SDA low only while SCL is low, so SDA never changes while SCL is high within a data or acknowledge bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| strap_sel | input | 2 | Address strap code, becomes address bits [1:0] |
| reg_addr | output | PTR_W | Register pointer |
| reg_wdata | output | 16 | Word to write |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_rdata | input | 16 | Word at `reg_addr` |
| reg_rd | output | 1 | One-cycle strobe when a read captures `reg_rdata` |
| alert_pend | input | 1 | Latched-mode alert waiting for an alert response |
| high_flag | input | 1 | High-threshold flag sent as the last alert-response bit |
| alert_clr | output | 1 | One-cycle pulse when the alert response is won |
| defaults_rst | output | 1 | One-cycle pulse restoring register defaults |
| hs_mode | output | 1 | High-speed mode active |

## Verification
The bench goes after the edges of the transfer framing. It sends a fourth write byte, which a design with an unbounded byte counter would acknowledge and use to write a second word. It checks pointer retention and pointer reset: a design that cleared the pointer at STOP would return register 0 on the second read, and one that ignored the general call would return stale data. The alert response is played against a rival target with a lower address. A design that keeps driving after losing corrupts the last bit on the bus and clears an alert it did not deliver. The stuck-clock test holds SCL low during an acknowledge. A missing timeout leaves SDA held low for as long as SCL is held.

// File: rtl/i2c_tgt_pkg.sv
// Shared constants and state type for the serial target.
// Assumes 8-bit bus bytes and a 16-bit register word sent as two bytes.
package i2c_tgt_pkg;
    localparam int WORD_W = 16;
    localparam logic [4:0] DEV_ADDR_HI = 5'b10001;
    localparam logic [6:0] ALERT_RESP_ADDR = 7'b0001100;
    localparam logic [7:0] GC_RESET_CMD = 8'h06;
    localparam logic [4:0] HS_CODE_HI = 5'b00001;

    typedef enum logic [2:0] {
        S_IDLE, S_ADDR, S_WDATA, S_ACKOUT, S_RDATA, S_ACKIN, S_SKIP
    } tgt_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
// Brings SCL and SDA into the clock domain with two flops each and a third
// flop that gives the previous value. From these it derives clock edges and
// START/STOP events. Assumes bus levels stay stable for several system clocks.
module i2c_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [2:0] scl_p, sda_p;

    // shift the raw lines through the synchroniser chains (idle high)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_p <= 3'b111;
            sda_p <= 3'b111;
        end else begin
            scl_p <= {scl_p[1:0], scl_i};
            sda_p <= {sda_p[1:0], sda_i};
        end
    end

    assign scl_s     = scl_p[1];
    assign sda_s     = sda_p[1];
    assign scl_rise  = scl_p[1] & ~scl_p[2];
    assign scl_fall  = ~scl_p[1] & scl_p[2];
    assign start_det = scl_p[1] & scl_p[2] & sda_p[2] & ~sda_p[1];
    assign stop_det  = scl_p[1] & scl_p[2] & ~sda_p[2] & sda_p[1];
endmodule

// File: rtl/i2c_stuck_timer.sv
// Counts how long SCL has been low, in milliseconds, using a prescaler on
// the system clock. Gives a one-cycle timeout pulse at the limit.
// Assumes CLK_PER_MS >= 2.
module i2c_stuck_timer #(
    parameter int CLK_PER_MS = 250000,
    parameter int TIMEOUT_MS = 28
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    output logic tmo
);
    localparam int PRE_W = (CLK_PER_MS > 2) ? $clog2(CLK_PER_MS) : 1;
    localparam int MS_W  = (TIMEOUT_MS > 1) ? $clog2(TIMEOUT_MS) : 1;

    logic [PRE_W-1:0] pre;
    logic [MS_W-1:0]  ms;

    // count clocks and milliseconds while SCL stays low
    always_ff @(posedge clk) begin
        if (!rst_n || scl_s) begin
            pre <= '0;
            ms  <= '0;
            tmo <= 1'b0;
        end else begin
            tmo <= 1'b0;
            if (pre == PRE_W'(CLK_PER_MS - 1)) begin
                pre <= '0;
                if (ms == MS_W'(TIMEOUT_MS - 1)) begin
                    ms  <= '0;
                    tmo <= 1'b1;
                end else begin
                    ms <= ms + 1'b1;
                end
            end else begin
                pre <= pre + 1'b1;
            end
        end
    end

    AST_TMO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) tmo |=> !tmo) else $error("timeout pulse longer than one cycle"); // R7
endmodule

// File: rtl/i2c_tgt_engine.sv
// Byte-level engine of the serial target. It decodes the address byte and
// runs the pointer and data writes, two-byte reads, general-call reset,
// master-code detection and the alert response with arbitration. SDA drive
// changes only on a synchronised SCL falling edge.
// Assumes events come from i2c_line_sync and the timeout from i2c_stuck_timer.
module i2c_tgt_engine
    import i2c_tgt_pkg::*;
#(
    parameter int PTR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              tmo,
    input  logic [1:0]        strap_sel,
    input  logic [WORD_W-1:0] reg_rdata,
    input  logic              alert_pend,
    input  logic              high_flag,
    output logic              sda_oe,
    output logic [PTR_W-1:0]  reg_addr,
    output logic [WORD_W-1:0] reg_wdata,
    output logic              reg_wr,
    output logic              reg_rd,
    output logic              defaults_rst,
    output logic              alert_clr,
    output logic              hs_mode
);
    tgt_state_e        st;
    logic [3:0]        cnt;
    logic [7:0]        shreg, tx, wmsb;
    logic [WORD_W-1:0] rd_hold;
    logic [1:0]        strap_q, widx;
    logic              rd_mode, gc, ara, lost, ridx, mack;
    logic              hit_dev, hit_gc, hit_ara, hit_hs;

    // classify the received address byte
    always_comb begin
        hit_dev = shreg[7:1] == {DEV_ADDR_HI, strap_q};
        hit_gc  = shreg == 8'h00;
        hit_ara = (shreg == {ALERT_RESP_ADDR, 1'b1}) && alert_pend;
        hit_hs  = shreg[7:3] == HS_CODE_HI;
    end

    // bus protocol sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= S_IDLE; cnt <= '0; shreg <= '0; tx <= '0; wmsb <= '0;
            rd_hold <= '0; strap_q <= '0; widx <= '0; rd_mode <= 1'b0;
            gc <= 1'b0; ara <= 1'b0; lost <= 1'b0; ridx <= 1'b0; mack <= 1'b0;
            sda_oe <= 1'b0; reg_addr <= '0; reg_wdata <= '0; reg_wr <= 1'b0;
            reg_rd <= 1'b0; defaults_rst <= 1'b0; alert_clr <= 1'b0; hs_mode <= 1'b0;
        end else begin
            reg_wr <= 1'b0; reg_rd <= 1'b0; defaults_rst <= 1'b0; alert_clr <= 1'b0;
            if (tmo || stop_det) begin
                st <= S_IDLE; sda_oe <= 1'b0; hs_mode <= 1'b0;
            end else if (start_det) begin
                st <= S_ADDR; cnt <= '0; sda_oe <= 1'b0; strap_q <= strap_sel;
            end else begin
                unique case (st)
                    S_ADDR, S_WDATA: begin
                        if (scl_rise && cnt != 4'd8) begin
                            shreg <= {shreg[6:0], sda_s};
                            cnt   <= cnt + 4'd1;
                        end else if (scl_fall && cnt == 4'd8) begin
                            if (st == S_ADDR) begin
                                if (hit_dev) begin
                                    sda_oe <= 1'b1; st <= S_ACKOUT; rd_mode <= shreg[0];
                                    gc <= 1'b0; ara <= 1'b0; lost <= 1'b0; widx <= '0;
                                    if (shreg[0]) begin
                                        rd_hold <= reg_rdata; tx <= reg_rdata[15:8];
                                        ridx <= 1'b0; reg_rd <= 1'b1;
                                    end
                                end else if (hit_gc) begin
                                    sda_oe <= 1'b1; st <= S_ACKOUT; rd_mode <= 1'b0;
                                    gc <= 1'b1; ara <= 1'b0; widx <= '0;
                                end else if (hit_ara) begin
                                    sda_oe <= 1'b1; st <= S_ACKOUT; rd_mode <= 1'b1;
                                    gc <= 1'b0; ara <= 1'b1; lost <= 1'b0;
                                    tx <= {DEV_ADDR_HI, strap_q, high_flag};
                                end else begin
                                    st <= S_SKIP;
                                    if (hit_hs) hs_mode <= 1'b1;
                                end
                            end else if (gc) begin
                                if (widx == 2'd0 && shreg == GC_RESET_CMD) begin
                                    sda_oe <= 1'b1; st <= S_ACKOUT; widx <= 2'd1;
                                    defaults_rst <= 1'b1; reg_addr <= '0;
                                end else begin
                                    st <= S_SKIP;
                                end
                            end else if (widx == 2'd3) begin
                                st <= S_SKIP;
                            end else begin
                                sda_oe <= 1'b1; st <= S_ACKOUT; widx <= widx + 2'd1;
                                if (widx == 2'd0) reg_addr <= PTR_W'(shreg);
                                if (widx == 2'd1) wmsb <= shreg;
                                if (widx == 2'd2) begin
                                    reg_wdata <= {wmsb, shreg}; reg_wr <= 1'b1;
                                end
                            end
                        end
                    end
                    S_ACKOUT: begin
                        if (scl_fall) begin
                            cnt <= '0;
                            if (rd_mode) begin
                                st <= S_RDATA; sda_oe <= ~tx[7];
                            end else begin
                                st <= S_WDATA; sda_oe <= 1'b0;
                            end
                        end
                    end
                    S_RDATA: begin
                        if (scl_rise && cnt != 4'd8) begin
                            if (ara && tx[7] && !sda_s) lost <= 1'b1;
                            tx  <= {tx[6:0], 1'b0};
                            cnt <= cnt + 4'd1;
                        end else if (scl_fall && cnt == 4'd8) begin
                            sda_oe <= 1'b0; st <= S_ACKIN;
                            alert_clr <= ara & ~lost;
                        end else if (scl_fall) begin
                            sda_oe <= ~lost & ~tx[7];
                        end
                    end
                    S_ACKIN: begin
                        if (scl_rise) begin
                            mack <= ~sda_s;
                        end else if (scl_fall) begin
                            if (mack && !ara) begin
                                ridx   <= ~ridx;
                                tx     <= ridx ? rd_hold[15:8] : rd_hold[7:0];
                                sda_oe <= ~(ridx ? rd_hold[15] : rd_hold[7]);
                                cnt    <= '0;
                                st     <= S_RDATA;
                            end else begin
                                st <= S_SKIP;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n) $rose(sda_oe) |-> !scl_s) else $error("SDA drive began with SCL high"); // R10
    AST_DRIVE_ENGAGED: assert property (@(posedge clk) disable iff (!rst_n) sda_oe |-> (st == S_ACKOUT || st == S_RDATA)) else $error("SDA driven outside ack or read data"); // R4
    AST_HS_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (hs_mode && !stop_det && !tmo) |=> hs_mode) else $error("high-speed mode left without STOP"); // R6
    AST_TMO_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) tmo |=> (!sda_oe && st == S_IDLE)) else $error("timeout did not idle the engine"); // R7
    AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) reg_wr |=> !reg_wr) else $error("write strobe longer than one cycle"); // R2
    AST_CLR_WINNER: assert property (@(posedge clk) disable iff (!rst_n) alert_clr |-> (ara && !lost)) else $error("alert cleared without a won response"); // R9
endmodule

// File: rtl/sensor_i2c_target.sv
// Top level of the serial target. It connects the line synchroniser, the
// stuck-clock timer and the byte engine. Assumes SDA is wired open-drain
// outside the block, so that sda_oe = 1 pulls the line low.
module sensor_i2c_target #(
    parameter int PTR_W      = 8,
    parameter int CLK_PER_MS = 250000,
    parameter int TIMEOUT_MS = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe,
    input  logic [1:0]       strap_sel,
    output logic [PTR_W-1:0] reg_addr,
    output logic [15:0]      reg_wdata,
    output logic             reg_wr,
    input  logic [15:0]      reg_rdata,
    output logic             reg_rd,
    input  logic             alert_pend,
    input  logic             high_flag,
    output logic             alert_clr,
    output logic             defaults_rst,
    output logic             hs_mode
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det, tmo;

    i2c_line_sync u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2c_stuck_timer #(.CLK_PER_MS(CLK_PER_MS), .TIMEOUT_MS(TIMEOUT_MS)) u_timer (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .tmo(tmo)
    );

    i2c_tgt_engine #(.PTR_W(PTR_W)) u_engine (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
        .stop_det(stop_det), .tmo(tmo), .strap_sel(strap_sel),
        .reg_rdata(reg_rdata), .alert_pend(alert_pend), .high_flag(high_flag),
        .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .defaults_rst(defaults_rst),
        .alert_clr(alert_clr), .hs_mode(hs_mode)
    );
endmodule

// File: tb/tb_sensor_i2c_target.sv
`timescale 1ns/1ps
module tb_sensor_i2c_target;
    localparam int Q = 5;
    localparam int CPM = 20;
    localparam int TOMS = 28;

    logic clk = 1'b0, rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1, rival_oe = 1'b0;
    logic [1:0] strap = 2'd0;
    logic alert_pend = 1'b0, high_flag = 1'b0;
    logic sda_oe, reg_wr, reg_rd, alert_clr, defaults_rst, hs_mode;
    logic [7:0] reg_addr;
    logic [15:0] reg_wdata, reg_rdata;
    logic [15:0] rf [4];
    wire sda_bus = sda_m & ~sda_oe & ~rival_oe;

    int n_chk = 0, n_fail = 0, unstable = 0, bad_rise = 0;
    int wr_cnt = 0, rd_cnt = 0, clr_cnt = 0, gc_cnt = 0;
    logic [7:0] last_waddr;
    logic [15:0] last_wdata;
    logic oe_prev = 1'b0;
    bit done = 1'b0;
    int exp_rf [4];

    always #2 clk = ~clk;

    sensor_i2c_target #(.PTR_W(8), .CLK_PER_MS(CPM), .TIMEOUT_MS(TOMS)) dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
        .strap_sel(strap), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wr(reg_wr),
        .reg_rdata(reg_rdata), .reg_rd(reg_rd), .alert_pend(alert_pend),
        .high_flag(high_flag), .alert_clr(alert_clr), .defaults_rst(defaults_rst),
        .hs_mode(hs_mode)
    );

    function automatic logic [15:0] dflt(input int i);
        return 16'hC810 + 16'(i) * 16'h0111;
    endfunction

    // behavioural register file neighbour
    always @(posedge clk) begin
        if (!rst_n || defaults_rst) begin
            for (int i = 0; i < 4; i++) rf[i] <= dflt(i);
        end else if (reg_wr) begin
            rf[reg_addr[1:0]] <= reg_wdata;
        end
    end
    assign reg_rdata = rf[reg_addr[1:0]];

    // strobe monitors
    always @(posedge clk) begin
        if (reg_wr) begin wr_cnt++; last_waddr = reg_addr; last_wdata = reg_wdata; end
        if (reg_rd) rd_cnt++;
        if (alert_clr) clr_cnt++;
        if (defaults_rst) gc_cnt++;
    end

    // every clock: SDA drive must not begin while SCL is high
    always @(negedge clk) begin
        if (rst_n && sda_oe && !oe_prev && scl_m) bad_rise++;
        oe_prev = sda_oe;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic quarter();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; quarter(); scl_m = 1'b1; quarter(); sda_m = 1'b0; quarter(); scl_m = 1'b0; quarter();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; quarter(); scl_m = 1'b1; quarter(); sda_m = 1'b1; quarter();
    endtask

    // one clock period: value compared on every clock while SCL is high
    task automatic bit_cycle(input logic b, input logic rv, output logic s);
        logic first;
        sda_m = b; rival_oe = rv; quarter();
        scl_m = 1'b1;
        @(negedge clk) first = sda_bus;
        for (int i = 1; i < 2 * Q; i++) begin
            @(negedge clk);
            if (sda_bus !== first) unstable++;
        end
        s = first; scl_m = 1'b0; quarter();
        rival_oe = 1'b0;
    endtask

    task automatic wr_byte(input logic [7:0] d, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) bit_cycle(d[i], 1'b0, s);
        bit_cycle(1'b1, 1'b0, s);
        acked = ~s;
    endtask

    task automatic rd_byte(input logic mack, input logic [7:0] rival, input logic rv_en, output logic [7:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_cycle(1'b1, rv_en & ~rival[i], s);
            d[i] = s;
        end
        bit_cycle(~mack, 1'b0, s);
    endtask

    logic ak;
    logic [7:0] rb;
    int base;

    initial begin
        for (int i = 0; i < 4; i++) exp_rf[i] = int'(dflt(i));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 reset sda released", 32'(sda_oe), 0);
        chk("R10 reset hs_mode", 32'(hs_mode), 0);

        // full write: pointer 2, word ABCD, then an extra byte
        bus_start();
        wr_byte(8'h88, ak); chk("R1 address 44h acked", 32'(ak), 1);
        wr_byte(8'h02, ak); chk("R2 pointer byte acked", 32'(ak), 1);
        wr_byte(8'hAB, ak); chk("R2 high byte acked", 32'(ak), 1);
        wr_byte(8'hCD, ak); chk("R2 low byte acked", 32'(ak), 1);
        exp_rf[2] = 32'hABCD;
        chk("R2 one write strobe", 32'(wr_cnt), 1);
        chk("R2 write address", 32'(last_waddr), 2);
        chk("R2 write data", 32'(last_wdata), 32'hABCD);
        wr_byte(8'h11, ak); chk("R2 fourth byte not acked", 32'(ak), 0);
        chk("R2 no second strobe", 32'(wr_cnt), 1);
        bus_stop();

        // read back with ack then nack
        bus_start();
        wr_byte(8'h89, ak); chk("R3 read address acked", 32'(ak), 1);
        chk("R3 read strobe", 32'(rd_cnt), 1);
        rd_byte(1'b1, 8'h00, 1'b0, rb); chk("R3 high byte", 32'(rb), 32'(exp_rf[2] >> 8));
        rd_byte(1'b0, 8'h00, 1'b0, rb); chk("R3 low byte", 32'(rb), 32'(exp_rf[2] & 255));
        bus_stop();

        // pointer retained; nack after high byte releases the line
        bus_start();
        wr_byte(8'h89, ak);
        rd_byte(1'b0, 8'h00, 1'b0, rb); chk("R3 pointer retained", 32'(rb), 32'(exp_rf[2] >> 8));
        bit_cycle(1'b1, 1'b0, ak); chk("R4 line released after nack", 32'(ak), 1);
        chk("R4 no drive after nack", 32'(sda_oe), 0);
        bus_stop();

        // pointer-only write then read with wrap to the high byte
        bus_start();
        wr_byte(8'h88, ak); wr_byte(8'h01, ak);
        bus_stop();
        chk("R2 pointer write gives no strobe", 32'(wr_cnt), 1);
        bus_start();
        wr_byte(8'h89, ak);
        rd_byte(1'b1, 8'h00, 1'b0, rb); chk("R3 reg1 high", 32'(rb), 32'(exp_rf[1] >> 8));
        rd_byte(1'b1, 8'h00, 1'b0, rb); chk("R3 reg1 low", 32'(rb), 32'(exp_rf[1] & 255));
        rd_byte(1'b0, 8'h00, 1'b0, rb); chk("R3 repeat high", 32'(rb), 32'(exp_rf[1] >> 8));
        bus_stop();

        // strap decoding
        strap = 2'd1;
        bus_start(); wr_byte(8'h88, ak); chk("R1 44h rejected with strap 1", 32'(ak), 0); bus_stop();
        bus_start(); wr_byte(8'h8A, ak); chk("R1 45h acked with strap 1", 32'(ak), 1); bus_stop();
        strap = 2'd2;
        bus_start(); strap = 2'd0;
        wr_byte(8'h8C, ak); chk("R1 46h acked, strap taken at START", 32'(ak), 1); bus_stop();
        strap = 2'd3;
        bus_start(); wr_byte(8'h8E, ak); chk("R1 47h acked with strap 3", 32'(ak), 1); bus_stop();
        strap = 2'd0;

        // general call reset
        bus_start();
        wr_byte(8'h00, ak); chk("R5 general call acked", 32'(ak), 1);
        wr_byte(8'h06, ak); chk("R5 reset command acked", 32'(ak), 1);
        bus_stop();
        for (int i = 0; i < 4; i++) exp_rf[i] = int'(dflt(i));
        chk("R5 defaults pulse", 32'(gc_cnt), 1);
        bus_start(); wr_byte(8'h89, ak);
        rd_byte(1'b0, 8'h00, 1'b0, rb); chk("R5 pointer cleared", 32'(rb), 32'(exp_rf[0] >> 8));
        bus_stop();
        bus_start(); wr_byte(8'h88, ak); wr_byte(8'h02, ak); bus_stop();
        bus_start(); wr_byte(8'h89, ak);
        rd_byte(1'b0, 8'h00, 1'b0, rb); chk("R5 reg2 back to default", 32'(rb), 32'(exp_rf[2] >> 8));
        bus_stop();
        bus_start();
        wr_byte(8'h00, ak); wr_byte(8'h05, ak); chk("R5 other command not acked", 32'(ak), 0);
        bus_stop();
        chk("R5 no pulse for other command", 32'(gc_cnt), 1);

        // high-speed master code
        bus_start();
        wr_byte(8'h0B, ak); chk("R6 master code not acked", 32'(ak), 0);
        chk("R6 hs set", 32'(hs_mode), 1);
        bus_start();
        wr_byte(8'h88, ak); chk("R6 address acked in hs", 32'(ak), 1);
        chk("R6 hs held over repeated START", 32'(hs_mode), 1);
        bus_stop();
        chk("R6 hs cleared at STOP", 32'(hs_mode), 0);

        // stuck clock during an acknowledge
        bus_start();
        for (int i = 7; i >= 0; i--) bit_cycle(((8'h88 >> i) & 8'h01) != 0, 1'b0, ak);
        repeat (500 - Q) @(negedge clk);
        chk("R7 ack still driven before limit", 32'(sda_oe), 1);
        repeat (100) @(negedge clk);
        chk("R7 released after timeout", 32'(sda_oe), 0);
        bus_stop();
        bus_start(); wr_byte(8'h88, ak); chk("R7 transfer after timeout", 32'(ak), 1); bus_stop();

        // alert response
        bus_start(); wr_byte(8'h19, ak); chk("R8 no ack without alert", 32'(ak), 0); bus_stop();
        alert_pend = 1'b1; high_flag = 1'b1;
        base = clr_cnt;
        bus_start();
        wr_byte(8'h19, ak); chk("R8 alert response acked", 32'(ak), 1);
        rd_byte(1'b0, 8'h00, 1'b0, rb); chk("R8 address with high flag", 32'(rb), 32'h89);
        bus_stop();
        chk("R8 alert cleared", 32'(clr_cnt), 32'(base + 1));

        // lose arbitration against a target at 44h
        strap = 2'd3; high_flag = 1'b0;
        bus_start();
        wr_byte(8'h19, ak);
        rd_byte(1'b0, 8'h89, 1'b1, rb); chk("R9 bus carries winner byte", 32'(rb), 32'h89);
        bus_stop();
        chk("R9 loser keeps alert", 32'(clr_cnt), 32'(base + 1));
        chk("R9 loser released", 32'(sda_oe), 0);

        chk("R10 no drive start with SCL high", 32'(bad_rise), 0);
        chk("R10 bits stable while SCL high", 32'(unstable), 0);

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule